// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that holds a small byte-wide register file. It oversamples the SCL and SDA lines on the system clock. From those samples it recognises start, repeated-start and stop conditions, and it shifts bytes in and out. It answers only when the 7-bit device address that follows a start matches the `DEV_ADDR` parameter.

After a write-direction address, the master sends a word index of one or two bytes, selected by `wide_index`. The index loads an internal pointer. Later bytes in the same transfer are stored at the pointer, which steps forward after each byte.

To read, the master sends a write-direction address and an index with no data bytes, issues a repeated start, and then sends a read-direction address. The target then returns bytes from the indexed location for as long as the master acknowledges them. The target never drives SDA high. Its only SDA output is a pull-low enable, to be combined with a pull-up resistor on the board.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and every register file entry reads back as 0x00.
- R2: A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. Both are recognised in any state. A stop abandons any partial byte without storing it and leaves SDA released.
- R3: The first byte after a start carries a 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). The target acknowledges the byte only when the address equals `DEV_ADDR`.
- R4: After a non-matching address, the target acknowledges nothing, drives nothing and stores nothing until the next start or stop.
- R5: The target pulls SDA low during the 9th clock after a matching address and after each received byte. It releases SDA after the falling SCL edge that ends that clock. `sda_pull_o` changes only while SCL is low.
- R6: With `wide_index`=0, the single byte after a write address sets the pointer to that byte modulo `DEPTH`.
- R7: With `wide_index`=1, the two bytes after a write address form a 16-bit index, high byte first. The pointer is set to that index modulo `DEPTH`.
- R8: Each further byte in a write transfer is stored at the pointer. The pointer then increments, and the byte is acknowledged.
- R9: An index-only write followed by a repeated start and a read address returns the byte at the pointer, MSB first, with bits changing while SCL is low.
- R10: In a read, a master acknowledge (SDA low in the 9th clock) makes the target send the next byte. A not-acknowledge ends the read with SDA released. The pointer advances once per byte sent, so a later read without a new index continues from there.
- R11: The pointer wraps from `DEPTH`-1 to 0 for both writes and reads.
- R12: The SDA output is a pull-low enable only. A 1 data bit leaves the line to the pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| wide_index | input | 1 | 1 selects a two-byte word index, 0 a one-byte index |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume a well-behaved master. SDA moves only while SCL is low, except when the master forms a start or a stop. Every bus edge is also held longer than the synchroniser latency, so the target sees each SCL level before the next SDA change. The bench drives the bus with a quarter-bit period of ten system clocks, and it changes SDA only in the middle of an SCL low phase or inside a deliberate start or stop. The bench models the open-drain line as the AND of the master's and the target's releases, so the target's pull is seen on `sda_i` just as on a real wired bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        ROLE_DEV,
        ROLE_IDX_HI,
        ROLE_IDX_LO,
        ROLE_DATA
    } byte_role_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    localparam int BYTE_BITS = 8;

    function automatic byte_role_e role_after_dev(input logic wide);
        return wide ? ROLE_IDX_HI : ROLE_IDX_LO;
    endfunction

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t ev
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] scl_p;
    logic [CHAIN-1:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[CHAIN-2:0], scl_i};
            sda_p <= {sda_p[CHAIN-2:0], sda_i};
        end
    end

    logic scl_now, scl_was, sda_now, sda_was;
    assign scl_now = scl_p[SYNC_STAGES-1];
    assign scl_was = scl_p[SYNC_STAGES];
    assign sda_now = sda_p[SYNC_STAGES-1];
    assign sda_was = sda_p[SYNC_STAGES];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_was;
        ev.scl_fall = ~scl_now & scl_was;
        ev.start    = scl_now & scl_was & sda_was & ~sda_now;
        ev.stop     = scl_now & scl_was & ~sda_was & sda_now;
    end
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         AW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  line_evt_t     ev,
    input  logic          wide_index,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_pull
);
    tgt_state_e state;
    byte_role_e role;
    logic [7:0] shreg;
    logic [7:0] idx_hi;
    logic [3:0] bitn;
    logic       read_dir;
    logic       more;
    logic [15:0] full_idx;

    assign full_idx = wide_index ? {idx_hi, shreg} : {8'h00, shreg};

    // a byte bound for the register file completes on the falling edge after bit 8
    assign wr_en   = (state == ST_RECV) && ev.scl_fall && (bitn == 4'(BYTE_BITS))
                     && (role == ROLE_DATA) && !ev.start && !ev.stop;
    assign wr_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            role     <= ROLE_DEV;
            shreg    <= 8'h00;
            idx_hi   <= 8'h00;
            bitn     <= 4'd0;
            read_dir <= 1'b0;
            more     <= 1'b0;
            ptr      <= '0;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_RECV;
            role     <= ROLE_DEV;
            bitn     <= 4'd0;
            sda_pull <= 1'b0;
        end else if (ev.stop) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_RECV: begin
                    if (ev.scl_rise && bitn != 4'(BYTE_BITS)) begin
                        shreg <= {shreg[6:0], ev.sda};
                        bitn  <= bitn + 4'd1;
                    end else if (ev.scl_fall && bitn == 4'(BYTE_BITS)) begin
                        unique case (role)
                            ROLE_DEV: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    read_dir <= shreg[0];
                                    role     <= role_after_dev(wide_index);
                                    sda_pull <= 1'b1;
                                    state    <= ST_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                            ROLE_IDX_HI: begin
                                idx_hi   <= shreg;
                                role     <= ROLE_IDX_LO;
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                            end
                            ROLE_IDX_LO: begin
                                ptr      <= full_idx[AW-1:0];
                                role     <= ROLE_DATA;
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                            end
                            default: begin
                                ptr      <= ptr + AW'(1);
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bitn <= 4'd0;
                        if (read_dir) begin
                            shreg    <= rd_data;
                            ptr      <= ptr + AW'(1);
                            sda_pull <= ~rd_data[7];
                            state    <= ST_SEND;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_RECV;
                        end
                    end
                end
                ST_SEND: begin
                    if (ev.scl_fall) begin
                        if (bitn == 4'(BYTE_BITS - 1)) begin
                            sda_pull <= 1'b0;
                            state    <= ST_MACK;
                        end else begin
                            shreg    <= {shreg[6:0], 1'b0};
                            sda_pull <= ~shreg[6];
                            bitn     <= bitn + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        more <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (more) begin
                            shreg    <= rd_data;
                            ptr      <= ptr + AW'(1);
                            sda_pull <= ~rd_data[7];
                            bitn     <= 4'd0;
                            state    <= ST_SEND;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         DEPTH       = 64,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wide_index,
    output logic sda_pull_o
);
    localparam int AW = $clog2(DEPTH);

    line_evt_t     ev;
    logic [AW-1:0] ptr;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          scl_lvl;
    logic          stop_seen;

    assign scl_lvl   = ev.scl;
    assign stop_seen = ev.stop;

    i2c_tgt_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .wide_index (wide_index),
        .rd_data    (mem_rdata),
        .ptr        (ptr),
        .wr_en      (mem_we),
        .wr_data    (mem_wdata),
        .sda_pull   (sda_pull_o)
    );

    i2c_tgt_regfile #(.DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .idx   (ptr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
    input logic clk,
    input logic rst,
    input logic sda_pull_o,
    input logic scl_lvl,
    input logic stop_seen,
    input logic mem_we
);
    AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> !sda_pull_o); // R1

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !$past(scl_lvl)); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $past(stop_seen) |-> !sda_pull_o); // R2

    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sda_pull_o); // R8

    AST_WRITE_LINE_FREE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !sda_pull_o); // R12
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull_o (sda_pull_o),
    .scl_lvl    (scl_lvl),
    .stop_seen  (stop_seen),
    .mem_we     (mem_we)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
    localparam logic [6:0] ADDR = 7'h50;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic wide = 1'b0;
    logic sda_pull;
    wire  sda_bus = ~(m_low | sda_pull);

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    i2c_reg_target #(.DEV_ADDR(ADDR), .DEPTH(64)) i_i2c_reg_target (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .wide_index (wide),
        .sda_pull_o (sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; tick(Q);
            m_scl = 1'b1;  tick(2 * Q);
            m_scl = 1'b0;  tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            d[i] = sda_bus;
            tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_low = give_ack;
        tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    // index phase shared by writes and dummy writes
    task automatic send_index(input logic [15:0] idx, input string req);
        logic a;
        send_byte({ADDR, 1'b0}, a);
        chk({req, " R3 address ack"}, a, 1'b1);
        if (wide) begin
            send_byte(idx[15:8], a);
            chk({req, " R7 index high ack"}, a, 1'b1);
        end
        send_byte(idx[7:0], a);
        chk({req, " R5 index ack"}, a, 1'b1);
        chk({req, " R5 released after ack"}, sda_pull, 1'b0);
    endtask

    task automatic write_seq(input logic [15:0] idx, input logic [7:0] d [4], input int n, input string req);
        logic a;
        bus_start();
        send_index(idx, req);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], a);
            chk({req, " R8 data ack"}, a, 1'b1);
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [15:0] idx, input int n, output logic [7:0] d [4]);
        logic a;
        bus_start();
        send_index(idx, "R9");
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk("R9 read address ack", a, 1'b1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, d[k]);
        chk("R10 released after nack", sda_pull, 1'b0);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d [4];
        chk("R1 pull after reset", sda_pull, 1'b0);
        read_seq(16'h0000, 1, d);
        chk("R1 entry 0 cleared", d[0], 8'h00);
    endtask

    task automatic t_basic_write_read();
        logic [7:0] d [4];
        wide = 1'b0;
        write_seq(16'h0005, '{8'hA1, 8'hC3, 8'h00, 8'h00}, 2, "R6");
        read_seq(16'h0005, 2, d);
        chk("R9 R12 first byte", d[0], 8'hA1);
        chk("R10 second byte after master ack", d[1], 8'hC3);
    endtask

    task automatic t_index_modulo();
        logic [7:0] d [4];
        wide = 1'b0;
        write_seq(16'h0047, '{8'h5E, 8'h00, 8'h00, 8'h00}, 1, "R6");
        read_seq(16'h0007, 1, d);
        chk("R6 index taken modulo depth", d[0], 8'h5E);
    endtask

    task automatic t_wrong_address();
        logic a;
        logic [7:0] d [4];
        logic [7:0] r;
        bus_start();
        send_byte({7'h51, 1'b0}, a);
        chk("R4 no ack on mismatch", a, 1'b0);
        send_byte(8'h07, a);
        chk("R4 index ignored", a, 1'b0);
        send_byte(8'h00, a);
        chk("R4 data ignored", a, 1'b0);
        bus_stop();
        bus_start();
        send_byte({7'h33, 1'b1}, a);
        chk("R4 no ack on read mismatch", a, 1'b0);
        recv_byte(1'b0, r);
        chk("R4 line left high", r, 8'hFF);
        bus_stop();
        read_seq(16'h0007, 1, d);
        chk("R4 memory untouched", d[0], 8'h5E);
    endtask

    task automatic t_two_byte_wrap();
        logic [7:0] d [4];
        wide = 1'b1;
        write_seq(16'h123E, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, "R7");
        read_seq(16'h003E, 3, d);
        chk("R7 byte at 62", d[0], 8'h11);
        chk("R11 byte at 63", d[1], 8'h22);
        chk("R11 read wraps to 0", d[2], 8'h33);
        read_seq(16'h0000, 1, d);
        chk("R11 write wrapped to 0", d[0], 8'h33);
        wide = 1'b0;
    endtask

    task automatic t_nack_continue();
        logic a;
        logic [7:0] d [4];
        logic [7:0] r;
        wide = 1'b0;
        read_seq(16'h0005, 1, d);
        chk("R10 single byte", d[0], 8'hA1);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        chk("R3 read address ack", a, 1'b1);
        recv_byte(1'b0, r);
        chk("R10 pointer advanced", r, 8'hC3);
        chk("R10 released after nack", sda_pull, 1'b0);
        bus_stop();
    endtask

    task automatic t_stop_abort();
        logic a;
        logic [7:0] d [4];
        wide = 1'b0;
        bus_start();
        send_index(16'h0010, "R2");
        send_byte(8'h5A, a);
        chk("R8 data ack", a, 1'b1);
        send_bits(8'hE7, 4);
        bus_stop();
        chk("R2 released after stop", sda_pull, 1'b0);
        read_seq(16'h0010, 2, d);
        chk("R2 full byte kept", d[0], 8'h5A);
        chk("R2 partial byte dropped", d[1], 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_basic_write_read();
        t_index_modulo();
        t_wrong_address();
        t_two_byte_wrap();
        t_nack_continue();
        t_stop_abort();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule